// File: doc/BRIEF.md
# Charge-Balance Integrator Feedback Controller

This block is the digital side of an integrating analog-to-digital converter. An outside analog integrator drives two comparators, one at a positive quantum threshold and one at a negative one. The integrator is balanced by two feedback switches. The controller checks the two comparator flags once per feedback period. When exactly one flag is set, it closes the matching switch for a fixed half-period, which removes one quantum of charge. On the same clock edge it steps a signed up/down counter by one.

The counter holds the running integral as a count of quanta. Scaling by the quantum size is left to the host. The host takes a snapshot of the count by pulsing a read request, and counting carries on undisturbed. A single request puts the block into run mode. From then on it keeps balancing and counting until reset: there is no hold state and no integrator reset state. The count can be cleared only before the run starts. Simultaneous flags and counter saturation are reported on sticky flags.

Top module: `qbal_ctrl`

## Requirements
- R1: A positive-threshold flag (`cmp_pos`) drives pulses only on `sw_pos`, and a negative-threshold flag (`cmp_neg`) drives pulses only on `sw_neg`. The two switch outputs are never high in the same cycle.
- R2: Each comparator flag passes through a two-stage synchronizer. The synchronized flags are sampled only in the first cycle of each `PERIOD_CYC`-cycle feedback period, so at most one pulse starts per period. A flag that drops before the next sample causes exactly one pulse.
- R3: Every feedback pulse is high for exactly `PERIOD_CYC/2` consecutive clock cycles.
- R4: The counter changes on the same clock edge as the pulse rises. A `sw_pos` pulse adds one and a `sw_neg` pulse subtracts one.
- R5: While idle (`running` = 0), comparator flags cause no pulses and leave the count unchanged. A one-cycle `run_req` sets `running` to 1 on the next edge.
- R6: Once `running` is 1 it stays 1 until `rst_n` is asserted, whatever `run_req` and `clr` do.
- R7: If both synchronized flags are high at the same sample, no pulse is issued and no count is made. The sticky `both_err` flag is then set.
- R8: The counter is `CNT_W`-bit two's complement and saturates at its most positive and most negative values. At a limit the pulse is still issued, the step is dropped, and the sticky `ovf_err` flag is set.
- R9: A `rd_req` held high in a cycle loads the counter value into `rd_data` on that clock edge (two's complement, `CNT_W` bits). It does not alter the counter.
- R10: `clr` zeroes the counter only while idle. While running it has no effect on the count.
- R11: After reset, `running`, `sw_pos`, `sw_neg`, `both_err`, `ovf_err` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | Pulse to enter run mode |
| clr | input | 1 | Synchronous counter clear, honoured only while idle |
| cmp_pos | input | 1 | Positive-threshold comparator flag (asynchronous) |
| cmp_neg | input | 1 | Negative-threshold comparator flag (asynchronous) |
| rd_req | input | 1 | Snapshot request for the readout register |
| sw_pos | output | 1 | Feedback switch for a positive crossing |
| sw_neg | output | 1 | Feedback switch for a negative crossing |
| running | output | 1 | Run mode active |
| rd_data | output | CNT_W | Last snapshot of the signed count |
| both_err | output | 1 | Sticky: both flags seen at one sample |
| ovf_err | output | 1 | Sticky: a step was dropped at a counter limit |

## Verification
The bound checker covers the rules that hold on every cycle:
- the two switches are never high together;
- each pulse lasts exactly half a period;
- the counter moves by one in the pulse's direction on its rising edge, unless it is at a limit;
- run mode and the sticky flags never fall;
- a simultaneous-flag event never produces a pulse.

Some behaviour can only be shown by the directed scenarios:
- the count seen through snapshots after a sequence of stimuli;
- a dropped flag giving exactly one pulse;
- flags and `clr` being ignored in the respective modes;
- saturation at both ends of a narrow counter.

// File: rtl/qbal_pkg.sv
package qbal_pkg;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } dir_e;

    // Direction chosen from one sample of the synchronized flags.
    function automatic dir_e pick_dir(input logic pos, input logic neg);
        if (pos && !neg)      return DIR_UP;
        else if (neg && !pos) return DIR_DN;
        else                  return DIR_NONE;
    endfunction

endpackage

// File: rtl/qbal_sync.sv
module qbal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qbal_phase.sv
module qbal_phase #(
    parameter int PERIOD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic start,
    output logic first_half
);
    localparam int PW   = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam int HALF = PERIOD_CYC / 2;

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = '0;
        if (en) begin
            if (phase_q == PW'(PERIOD_CYC - 1)) phase_d = '0;
            else                                phase_d = phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign start      = en && (phase_q == '0);
    assign first_half = (phase_q < PW'(HALF));
endmodule

// File: rtl/qbal_updn.sv
module qbal_updn
    import qbal_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  dir_e             step,
    output logic [CNT_W-1:0] cnt,
    output logic             sat_hit
);
    localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        sat_hit = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else begin
            case (step)
                DIR_UP: begin
                    if (cnt_q == CMAX) sat_hit = 1'b1;
                    else               cnt_d   = cnt_q + 1'b1;
                end
                DIR_DN: begin
                    if (cnt_q == CMIN) sat_hit = 1'b1;
                    else               cnt_d   = cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/qbal_ctrl.sv
module qbal_ctrl
    import qbal_pkg::*;
#(
    parameter int PERIOD_CYC  = 8,
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             clr,
    input  logic             cmp_pos,
    input  logic             cmp_neg,
    input  logic             rd_req,
    output logic             sw_pos,
    output logic             sw_neg,
    output logic             running,
    output logic [CNT_W-1:0] rd_data,
    output logic             both_err,
    output logic             ovf_err
);
    typedef struct packed {
        logic             run;
        logic             sw_pos;
        logic             sw_neg;
        logic             both_err;
        logic             ovf_err;
        logic [CNT_W-1:0] rd;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic             pos_s, neg_s;
    logic             start, first_half;
    logic             sat_hit;
    dir_e             dec;
    logic [CNT_W-1:0] cnt_val;

    qbal_sync #(.STAGES(SYNC_STAGES)) i_sync_pos (
        .clk(clk), .rst_n(rst_n), .d(cmp_pos), .q(pos_s)
    );
    qbal_sync #(.STAGES(SYNC_STAGES)) i_sync_neg (
        .clk(clk), .rst_n(rst_n), .d(cmp_neg), .q(neg_s)
    );

    qbal_phase #(.PERIOD_CYC(PERIOD_CYC)) i_phase (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.run),
        .start(start), .first_half(first_half)
    );

    qbal_updn #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(clr && !ctl_q.run),
        .step(dec),
        .cnt(cnt_val),
        .sat_hit(sat_hit)
    );

    always_comb begin
        dec      = start ? pick_dir(pos_s, neg_s) : DIR_NONE;
        ctl_d    = ctl_q;
        ctl_d.run = ctl_q.run | run_req;
        if (start) begin
            ctl_d.sw_pos = (dec == DIR_UP);
            ctl_d.sw_neg = (dec == DIR_DN);
        end else begin
            ctl_d.sw_pos = ctl_q.sw_pos && first_half;
            ctl_d.sw_neg = ctl_q.sw_neg && first_half;
        end
        ctl_d.both_err = ctl_q.both_err | (start && pos_s && neg_s);
        ctl_d.ovf_err  = ctl_q.ovf_err | sat_hit;
        if (rd_req) ctl_d.rd = cnt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sw_pos   = ctl_q.sw_pos;
    assign sw_neg   = ctl_q.sw_neg;
    assign running  = ctl_q.run;
    assign rd_data  = ctl_q.rd;
    assign both_err = ctl_q.both_err;
    assign ovf_err  = ctl_q.ovf_err;
endmodule

// File: rtl/qbal_ctrl_chk.sv
module qbal_ctrl_chk #(
    parameter int PERIOD_CYC = 8,
    parameter int CNT_W      = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_pos,
    input logic             sw_neg,
    input logic             running,
    input logic             both_err,
    input logic             ovf_err,
    input logic [CNT_W-1:0] cnt
);
    localparam int HALF = PERIOD_CYC / 2;
    localparam int WW   = $clog2(PERIOD_CYC + 1);
    localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};

    logic          any_sw;
    logic [WW-1:0] width_q;

    assign any_sw = sw_pos | sw_neg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      width_q <= '0;
        else if (any_sw) width_q <= width_q + 1'b1;
        else             width_q <= '0;
    end

    p_excl_sw_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_pos && sw_neg));

    p_width_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= WW'(HALF));

    p_width_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_sw && $past(any_sw)) |-> (width_q == WW'(HALF)));

    p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_pos && !$past(sw_pos) && $past(cnt) != CMAX) |-> (cnt == $past(cnt) + 1'b1));

    p_count_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_neg && !$past(sw_neg) && $past(cnt) != CMIN) |-> (cnt == $past(cnt) - 1'b1));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!sw_pos && !sw_neg));

    p_run_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(running) |-> running);

    p_both_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(both_err) |-> (!sw_pos && !sw_neg));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_err) |-> ovf_err);

    p_both_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(both_err) |-> both_err);
endmodule

bind qbal_ctrl qbal_ctrl_chk #(.PERIOD_CYC(PERIOD_CYC), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .sw_pos(sw_pos), .sw_neg(sw_neg),
    .running(running), .both_err(both_err), .ovf_err(ovf_err), .cnt(cnt_val)
);

// File: tb/test_qbal_ctrl.sv
module test_qbal_ctrl;
    localparam int PER   = 8;
    localparam int W     = 4;
    localparam int HALF  = PER / 2;
    localparam int CMAXV = 7;
    localparam int CMINV = -8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_req = 0, clr = 0, cmp_pos = 0, cmp_neg = 0, rd_req = 0;
    logic sw_pos, sw_neg, running, both_err, ovf_err;
    logic [W-1:0] rd_data;

    int checks = 0, failures = 0;
    int pos_pulses = 0, neg_pulses = 0;
    int cur_w = 0, bad_w = 0, overlap = 0;
    logic pos_l = 0, neg_l = 0;

    always #5 clk = ~clk;

    qbal_ctrl #(.PERIOD_CYC(PER), .CNT_W(W)) i_qbal_ctrl (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .clr(clr),
        .cmp_pos(cmp_pos), .cmp_neg(cmp_neg), .rd_req(rd_req),
        .sw_pos(sw_pos), .sw_neg(sw_neg), .running(running),
        .rd_data(rd_data), .both_err(both_err), .ovf_err(ovf_err)
    );

    // Pulse monitor: counts rising edges and checks each pulse width.
    always @(posedge clk) begin
        if (sw_pos && !pos_l) pos_pulses++;
        if (sw_neg && !neg_l) neg_pulses++;
        if (sw_pos && sw_neg) overlap++;
        if (sw_pos || sw_neg) cur_w++;
        else begin
            if ((pos_l || neg_l) && cur_w != HALF) bad_w++;
            cur_w = 0;
        end
        pos_l = sw_pos;
        neg_l = sw_neg;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap(output int val);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        val = $signed(rd_data);
    endtask

    task automatic t_reset;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(!running && !sw_pos && !sw_neg && !both_err && !ovf_err && rd_data == 0,
            "R11 reset state", int'({running, sw_pos, sw_neg, both_err, ovf_err}), 0);
    endtask

    task automatic t_idle;
        int v;
        cmp_pos = 1'b1;
        wait_cyc(3 * PER);
        cmp_pos = 1'b0;
        clr = 1'b1; wait_cyc(1); clr = 1'b0;
        wait_cyc(4);
        chk(pos_pulses == 0 && neg_pulses == 0, "R5 no pulses while idle", pos_pulses + neg_pulses, 0);
        snap(v);
        chk(v == 0, "R5 R10 count zero while idle", v, 0);
    endtask

    task automatic t_start;
        @(negedge clk) run_req = 1'b1;
        @(negedge clk) run_req = 1'b0;
        chk(running, "R5 run starts", int'(running), 1);
    endtask

    task automatic one_pulse(input bit up);
        if (up) cmp_pos = 1'b1; else cmp_neg = 1'b1;
        if (up) wait (sw_pos == 1'b1); else wait (sw_neg == 1'b1);
        @(negedge clk);
        cmp_pos = 1'b0; cmp_neg = 1'b0;
        wait_cyc(3 * PER);
    endtask

    task automatic t_single_up;
        int v;
        one_pulse(1'b1);
        chk(pos_pulses == 1 && neg_pulses == 0, "R1 R2 one pulse on sw_pos", pos_pulses, 1);
        chk(bad_w == 0, "R3 pulse width", bad_w, 0);
        snap(v);
        chk(v == 1, "R4 R9 count up", v, 1);
    endtask

    task automatic t_single_down;
        int v;
        one_pulse(1'b0);
        one_pulse(1'b0);
        chk(neg_pulses == 2 && pos_pulses == 1, "R1 R2 two pulses on sw_neg", neg_pulses, 2);
        snap(v);
        chk(v == -1, "R4 count down", v, -1);
    endtask

    task automatic t_both;
        int v, p0;
        p0 = pos_pulses + neg_pulses;
        @(negedge clk) begin cmp_pos = 1'b1; cmp_neg = 1'b1; end
        wait_cyc(3 * PER);
        cmp_pos = 1'b0; cmp_neg = 1'b0;
        wait_cyc(2 * PER);
        chk(pos_pulses + neg_pulses == p0, "R7 no pulse on both", pos_pulses + neg_pulses, p0);
        chk(both_err, "R7 both_err set", int'(both_err), 1);
        snap(v);
        chk(v == -1, "R7 count unchanged", v, -1);
    endtask

    task automatic t_clr_run;
        int v;
        @(negedge clk) begin clr = 1'b1; run_req = 1'b1; end
        wait_cyc(3);
        clr = 1'b0; run_req = 1'b0;
        wait_cyc(PER);
        chk(running, "R6 stays running", int'(running), 1);
        snap(v);
        chk(v == -1, "R10 clr ignored while running", v, -1);
        chk(!ovf_err, "R8 no overflow yet", int'(ovf_err), 0);
    endtask

    task automatic t_sat_up;
        int v, p0, n, e;
        p0 = pos_pulses;
        @(negedge clk) cmp_pos = 1'b1;
        wait_cyc(12 * PER);
        cmp_pos = 1'b0;
        wait_cyc(2 * PER);
        n = pos_pulses - p0;
        chk(n >= 11, "R8 pulses continue at limit", n, 12);
        e = (-1 + n > CMAXV) ? CMAXV : -1 + n;
        snap(v);
        chk(v == e && v == CMAXV, "R8 saturate high", v, CMAXV);
        chk(ovf_err, "R8 ovf_err set", int'(ovf_err), 1);
        chk(bad_w == 0 && overlap == 0, "R1 R3 widths and exclusion", bad_w + overlap, 0);
    endtask

    task automatic t_sat_down;
        int v, mid;
        @(negedge clk) cmp_neg = 1'b1;
        wait_cyc(4 * PER);
        snap(mid);
        wait_cyc(16 * PER);
        cmp_neg = 1'b0;
        wait_cyc(2 * PER);
        chk(mid < CMAXV && mid > CMINV, "R9 snapshot mid-run", mid, 3);
        snap(v);
        chk(v == CMINV, "R8 R9 saturate low after snapshot", v, CMINV);
        chk(running && ovf_err, "R6 R8 still running, flag sticky", int'({running, ovf_err}), 3);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_start();
        t_single_up();
        t_single_down();
        t_both();
        t_clr_run();
        t_sat_up();
        t_sat_down();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule